// File: doc/BRIEF.md
# Pipelined Unsigned Array Multiplier

This block multiplies an N-bit unsigned multiplicand by an M-bit unsigned multiplier and returns the full N+M bit product. It is organised as a column of M adder rows. Each row adds the multiplicand, gated by one multiplier bit, into a running partial sum, and a register bank follows every row. A fresh operand pair may therefore be presented on every clock. Each result appears a fixed M clocks after its operands were taken.

Each stage keeps only what later stages still need. That is the multiplicand (not kept after the last row), the upper N bits of the running sum, the multiplier bits not yet consumed and the product bits that are already final. The unconsumed multiplier bits shrink by one per stage and the settled low product bits grow by one per stage. A valid flag travels with the data. The data registers load only when that flag is set, so the output holds its last result between valid outputs.

Top module: `arr_mult_pipe`

## Requirements
- R1: When `out_valid` is high, `prod_out` equals the unsigned product of the `x_in` and `y_in` values sampled with the matching `in_valid`, at the full N+M bit width (with N=6, M=4: 42 times 10 gives 420).
- R2: `out_valid` is high exactly on the M-th rising edge after a rising edge at which `in_valid` was sampled high, and is low in every other cycle.
- R3: Operand pairs presented on consecutive cycles are all accepted, and their products come out on consecutive cycles in the same order.
- R4: While `out_valid` is low, `prod_out` keeps the value of the most recent valid result (zero if there is none since reset).
- R5: `rst` is synchronous and active high. On the edge after it is sampled high, `out_valid` is low and `prod_out` is zero. Operand pairs in flight at that edge never appear at the output.
- R6: An operand of zero gives a product of zero, and all-ones operands give (2^N-1)(2^M-1) without any loss of high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair on x_in/y_in is to be multiplied |
| x_in | input | N | Unsigned multiplicand |
| y_in | input | M | Unsigned multiplier |
| out_valid | output | 1 | prod_out carries a new result this cycle |
| prod_out | output | N+M | Unsigned product |

## Verification
The bench builds the block with N=6 and M=4, so the product is 10 bits wide and the pipeline is four stages deep. At this size all 1024 operand pairs can be streamed back to back in one pass. That single pass covers the worked example, both all-zero and all-ones corners, and the carry out of every row. Separate scenarios insert idle cycles between pairs to expose the hold behaviour, and raise reset while pairs are in flight to show that they are discarded.

// File: rtl/arr_mult_pkg.sv
package arr_mult_pkg;

  // Bit offset of stage input i inside the triangular vector that holds
  // the multiplier bits still to be consumed (stage i carries m-i bits).
  function automatic int tri_y_off(input int m, input int i);
    return i * m - (i * (i - 1)) / 2;
  endfunction

  // Bit offset of stage input i inside the triangular vector that holds
  // the already settled low product bits (stage i carries i bits).
  function automatic int tri_l_off(input int i);
    return (i * (i - 1)) / 2;
  endfunction

endpackage

// File: rtl/pipe_reg.sv
module pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/mul_row.sv
module mul_row #(
  parameter int N = 8
) (
  input  logic [N-1:0] x,
  input  logic         ybit,
  input  logic [N-1:0] acc,
  output logic [N:0]   sum
);

  // One row of the array: gated multiplicand added into the running sum.
  function automatic logic [N:0] add_row(input logic [N-1:0] xv,
                                         input logic         b,
                                         input logic [N-1:0] av);
    logic [N-1:0] pp;
    pp = xv & {N{b}};
    return {1'b0, av} + {1'b0, pp};
  endfunction

  assign sum = add_row(x, ybit, acc);

endmodule

// File: rtl/arr_mult_pipe.sv
module arr_mult_pipe
  import arr_mult_pkg::*;
#(
  parameter int N = 8,
  parameter int M = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   x_in,
  input  logic [M-1:0]   y_in,
  output logic           out_valid,
  output logic [N+M-1:0] prod_out
);

  localparam int TRI = (M * (M + 1)) / 2;

  // Named stage-boundary signals (index i = input of stage i).
  logic [M:0]          stage_v;
  logic [M-1:0][N-1:0] stage_x;
  logic [M:0][N-1:0]   stage_acc;
  logic [TRI-1:0]      y_tri;
  logic [TRI-1:0]      low_tri;

  assign stage_v[0]   = in_valid;
  assign stage_x[0]   = x_in;
  assign stage_acc[0] = '0;
  assign y_tri[M-1:0] = y_in;

  for (genvar i = 0; i < M; i++) begin : g_stage
    localparam int YOFF = tri_y_off(M, i);
    localparam int YW   = M - i;
    localparam int LNXT = tri_l_off(i + 1);

    logic [N:0]    row_sum;
    logic [YW-1:0] y_here;
    logic [i:0]    low_d;

    assign y_here = y_tri[YOFF +: YW];

    mul_row #(.N(N)) u_row (
      .x    (stage_x[i]),
      .ybit (y_here[0]),
      .acc  (stage_acc[i]),
      .sum  (row_sum)
    );

    pipe_reg #(.W(1)) u_v (
      .clk (clk), .rst (rst), .en (1'b1),
      .d   (stage_v[i]), .q (stage_v[i+1])
    );

    pipe_reg #(.W(N)) u_acc (
      .clk (clk), .rst (rst), .en (stage_v[i]),
      .d   (row_sum[N:1]), .q (stage_acc[i+1])
    );

    if (i == 0) begin : g_low_first
      assign low_d = row_sum[0];
    end else begin : g_low_more
      assign low_d = {row_sum[0], low_tri[tri_l_off(i) +: i]};
    end

    pipe_reg #(.W(i + 1)) u_low (
      .clk (clk), .rst (rst), .en (stage_v[i]),
      .d   (low_d), .q (low_tri[LNXT +: i + 1])
    );

    if (i < M - 1) begin : g_fwd
      pipe_reg #(.W(N)) u_x (
        .clk (clk), .rst (rst), .en (stage_v[i]),
        .d   (stage_x[i]), .q (stage_x[i+1])
      );
      pipe_reg #(.W(YW - 1)) u_y (
        .clk (clk), .rst (rst), .en (stage_v[i]),
        .d   (y_here[YW-1:1]), .q (y_tri[tri_y_off(M, i + 1) +: YW - 1])
      );
    end
  end

  assign out_valid = stage_v[M];
  assign prod_out  = {stage_acc[M], low_tri[TRI-1 -: M]};

endmodule

// File: rtl/arr_mult_chk.sv
module arr_mult_chk
  import arr_mult_pkg::*;
#(
  parameter int N = 8,
  parameter int M = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    out_valid,
  input logic [N+M-1:0]          prod_out,
  input logic [M:0]              stage_v,
  input logic [M-1:0][N-1:0]     stage_x,
  input logic [(M*(M+1))/2-1:0]  low_tri
);

  assert_reset_clears_R5: assert property (@(posedge clk)
    rst |=> (!out_valid && prod_out == '0));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(prod_out));

  for (genvar i = 0; i < M; i++) begin : g_v
    assert_valid_advance_R2: assert property (@(posedge clk) disable iff (rst)
      stage_v[i] |=> stage_v[i+1]);
    assert_bubble_advance_R2: assert property (@(posedge clk) disable iff (rst)
      !stage_v[i] |=> !stage_v[i+1]);
  end

  for (genvar i = 0; i < M - 1; i++) begin : g_x
    assert_x_forward_R3: assert property (@(posedge clk) disable iff (rst)
      stage_v[i] |=> stage_x[i+1] == $past(stage_x[i]));
  end

  for (genvar i = 1; i < M; i++) begin : g_l
    assert_settled_kept_R1: assert property (@(posedge clk) disable iff (rst)
      stage_v[i] |=> low_tri[tri_l_off(i + 1) +: i] == $past(low_tri[tri_l_off(i) +: i]));
  end

endmodule

bind arr_mult_pipe arr_mult_chk #(.N(N), .M(M)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .prod_out  (prod_out),
  .stage_v   (stage_v),
  .stage_x   (stage_x),
  .low_tri   (low_tri)
);

// File: tb/arr_mult_pipe_tb.sv
module arr_mult_pipe_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N = 6;
  localparam int M = 4;
  localparam int W = N + M;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [N-1:0] x_in = '0;
  logic [M-1:0] y_in = '0;
  logic         out_valid;
  logic [W-1:0] prod_out;

  int n_chk  = 0;
  int n_fail = 0;
  int n_cyc  = 0;

  // Bench model: M-deep delay line of valid flags and expected products.
  logic         mv [M];
  logic [W-1:0] mp [M];
  logic [W-1:0] last_p = '0;

  arr_mult_pipe #(.N(N), .M(M)) u_dut (
    .clk (clk), .rst (rst), .in_valid (in_valid),
    .x_in (x_in), .y_in (y_in),
    .out_valid (out_valid), .prod_out (prod_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] ref_mul(input logic [N-1:0] a, input logic [M-1:0] b);
    return W'(a) * W'(b);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, update model at posedge, sample at next negedge.
  task automatic cycle(input logic r, input logic v, input logic [N-1:0] xv,
                       input logic [M-1:0] yv, input string tag);
    rst = r; in_valid = v; x_in = xv; y_in = yv;
    @(posedge clk);
    if (r) begin
      for (int k = 0; k < M; k++) begin mv[k] = 1'b0; mp[k] = '0; end
      last_p = '0;
    end else begin
      for (int k = M - 1; k > 0; k--) begin mv[k] = mv[k-1]; mp[k] = mp[k-1]; end
      mv[0] = v;
      mp[0] = ref_mul(xv, yv);
      if (mv[M-1]) last_p = mp[M-1];
    end
    @(negedge clk);
    check({tag, " valid"}, W'(out_valid), W'(mv[M-1]));
    check({tag, " product"}, prod_out, last_p);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cycle(1'b0, 1'b0, '0, '0, tag);
  endtask

  // R5: reset state.
  task automatic t_reset_state();
    cycle(1'b1, 1'b0, '0, '0, "R5");
    cycle(1'b1, 1'b1, 6'd7, 4'd3, "R5");
    idle(M + 1, "R5");
  endtask

  // R2 and R1: a single pair (42 x 10 = 420) surrounded by idle cycles.
  task automatic t_latency();
    cycle(1'b0, 1'b1, 6'd42, 4'd10, "R2");
    idle(M + 2, "R2");
    check("R1 example", prod_out, 10'd420);
  endtask

  // R6: corner operands back to back.
  task automatic t_corners();
    cycle(1'b0, 1'b1, 6'd0, 4'd15, "R6");
    cycle(1'b0, 1'b1, 6'd63, 4'd0, "R6");
    cycle(1'b0, 1'b1, 6'd63, 4'd15, "R6");
    cycle(1'b0, 1'b1, 6'd0, 4'd0, "R6");
    cycle(1'b0, 1'b1, 6'd63, 4'd15, "R6");
    idle(M + 1, "R6");
    check("R6 max", prod_out, 10'd945);
  endtask

  // R3 and R1: every operand pair streamed on consecutive cycles.
  task automatic t_sweep();
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << M); b++)
        cycle(1'b0, 1'b1, N'(a), M'(b), "R3");
    idle(M + 1, "R3");
  endtask

  // R4: gaps of varying length between pairs; product must hold.
  task automatic t_gaps();
    for (int k = 1; k < 9; k++) begin
      cycle(1'b0, 1'b1, N'(k * 7 + 3), M'(k * 5 + 1), "R4");
      idle(k % 3, "R4");
    end
    idle(M + 2, "R4");
  endtask

  // R5: reset while pairs are in flight discards them.
  task automatic t_reset_mid();
    cycle(1'b0, 1'b1, 6'd33, 4'd9, "R5");
    cycle(1'b0, 1'b1, 6'd21, 4'd14, "R5");
    cycle(1'b1, 1'b1, 6'd5, 4'd5, "R5");
    idle(M + 2, "R5");
    check("R5 flushed", prod_out, '0);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 200000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 200000 cycles", n_cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < M; k++) begin mv[k] = 1'b0; mp[k] = '0; end
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_corners();
    t_gaps();
    t_sweep();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule